// File: doc/BRIEF.md
# Vertical Wavelet Line Feeder

This block sits in front of the vertical lifting stage of a line-based two-dimensional integer 9/7M wavelet transform. One coefficient stream comes in from a horizontal pass, one sample per transfer, in raster order. Every row holds exactly `COLS` samples. The block keeps the most recent rows in a bank of seven line memories, each `COLS` entries deep. For every column of every output row pair it presents a five-value tuple to the lifting pipeline. The tuple values come from the same column of vertically neighbouring rows. The block also sends a flag that tells the pipeline when its previous-high-pass history must be mirrored.

Output row pair `n` needs rows `2n-2`, `2n`, `2n+1`, `2n+2` and `2n+4`. Rows outside the image are replaced by their mirror images about the top or bottom row. While a row is arriving, the block emits tuples that use that row as the newest tap, so it passes input through at full rate. When the stream marks the end of an image, the block stops taking input. It then replays stored rows to produce the last two output rows. The next image starts afresh. Storage depends only on `COLS`, so strips of any height, such as push-broom strips, can be processed.

Both stream interfaces are valid/ready. A transfer happens on a rising edge where valid and ready are both high. On the output side, valid and all payload fields hold steady until the transfer is taken. The input side may drop ready in two cases: the output register is full during a row that emits tuples, or the block is draining the bottom rows.

Top module: `vwf_vertical_feeder`

## Requirements
- R1: Image heights are even and at least 4. `s_eos` is honoured only on the final column of a row. An image of N rows yields exactly N/2 output rows of `COLS` tuples each, emitted with column order kept.
- R2: For output row pair n at column c, `m_tap0`..`m_tap4` carry, from column c, the samples of input rows 2n-2, 2n, 2n+1, 2n+2 and 2n+4, in that order.
- R3: At the top edge, a reference to row -2 uses row 2 instead.
- R4: At the bottom edge of an image with last row L=N-1, row L+1 is replaced by row L-1 and row L+3 by row L-3.
- R5: `m_left` is 1 on all `COLS` tuples of output pair 0 of each image and 0 on every other tuple.
- R6: Once the final sample with `s_eos` is accepted, and while back-pressure is absent, `s_ready` stays low for exactly 2*`COLS` cycles while the last two output rows drain.
- R7: While `m_valid` is 1 and `m_ready` is 0, the next cycle still shows `m_valid` 1 with every payload field unchanged.
- R8: Under any pattern of input gaps and output back-pressure, no tuple is lost, duplicated or reordered.
- R9: `m_eol` is 1 exactly on the tuple of the last column of each output row. `m_eos` is 1 only on the last tuple of an image.
- R10: An image that follows an earlier one without any idle gap is treated as a new image, with top mirroring and a fresh `m_left` row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Feeder accepts the input sample |
| s_data | input | DATA_W | Input coefficient |
| s_eos | input | 1 | Marks the final sample of an image |
| m_valid | output | 1 | Output tuple valid |
| m_ready | input | 1 | Downstream accepts the tuple |
| m_tap0 | output | DATA_W | Sample of row 2n-2 (mirrored if needed) |
| m_tap1 | output | DATA_W | Sample of row 2n |
| m_tap2 | output | DATA_W | Sample of row 2n+1 |
| m_tap3 | output | DATA_W | Sample of row 2n+2 (mirrored if needed) |
| m_tap4 | output | DATA_W | Sample of row 2n+4 (mirrored if needed) |
| m_left | output | 1 | Tuple belongs to the first output row pair |
| m_eol | output | 1 | Last column of an output row |
| m_eos | output | 1 | Last tuple of the image |

## Verification
A wrong slot pointer or row counter shows up at once as taps that hold samples from the wrong row. Every sample encodes its own image, row and column, so the first tuple of the affected row reveals the fault. A broken mirror choice is caught at the first or last output row of any image, and heights 4, 6, 8 and 10 put both edges in play. Drain or flag errors change how long `s_ready` stays low, or they misplace `m_left`, `m_eol` and `m_eos`, so the scoreboard sees a miscompare within one output row. A lost or repeated tuple under back-pressure shifts every following comparison.

// File: rtl/vwf_pkg.sv
package vwf_pkg;

  localparam int unsigned NUM_LINES = 7;

  typedef enum logic [1:0] {
    ST_RECV    = 2'd0,
    ST_DRAIN_A = 2'd1,
    ST_DRAIN_B = 2'd2
  } vwf_state_e;

  // slot of the row k rows older than the row held in slot s (modulo 7)
  function automatic logic [2:0] slot_back(input logic [2:0] s, input logic [2:0] k);
    logic [3:0] t;
    t = {1'b0, s} + 4'd7 - {1'b0, k};
    if (t >= 4'd7) t = t - 4'd7;
    return t[2:0];
  endfunction

endpackage

// File: rtl/vwf_line_bank.sv
module vwf_line_bank #(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned COLS   = 64,
  parameter int unsigned LINES  = 7,
  localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_slot,
  input  logic [COL_W-1:0]              col,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [LINES-1:0][DATA_W-1:0]  rd_lines
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [DATA_W-1:0] mem [COLS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == 3'(g))) mem[col] <= wr_data;
    end

    assign rd_lines[g] = mem[col];
  end

endmodule

// File: rtl/vwf_tap_mux.sv
module vwf_tap_mux #(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned LINES  = 7
) (
  input  logic [LINES-1:0][DATA_W-1:0] rd_lines,
  input  logic [2:0]                   sel,
  output logic [DATA_W-1:0]            tap
);

  always_comb begin
    tap = '0;
    for (int i = 0; i < LINES; i++) begin
      if (sel == 3'(i)) tap = rd_lines[i];
    end
  end

endmodule

// File: rtl/vwf_elastic_buf.sv
module vwf_elastic_buf #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         skid_valid;
  logic [W-1:0] skid_data;

  assign in_ready = !skid_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      skid_valid <= 1'b0;
    end else if (out_ready || !out_valid) begin
      if (skid_valid) begin
        out_valid  <= 1'b1;
        skid_valid <= 1'b0;
      end else begin
        out_valid <= in_valid;
      end
    end else if (in_valid && in_ready) begin
      skid_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (out_ready || !out_valid) begin
      if (skid_valid)    out_data <= skid_data;
      else if (in_valid) out_data <= in_data;
    end else if (in_valid && in_ready) begin
      skid_data <= in_data;
    end
  end

  // R7: a stalled output keeps valid and payload
  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: the skid entry is only occupied behind a full output register
  p_skid_behind_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

endmodule

// File: rtl/vwf_vertical_feeder.sv
module vwf_vertical_feeder
  import vwf_pkg::*;
#(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned COLS   = 64,
  localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned PAY_W = 5 * DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_eos,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_tap0,
  output logic [DATA_W-1:0] m_tap1,
  output logic [DATA_W-1:0] m_tap2,
  output logic [DATA_W-1:0] m_tap3,
  output logic [DATA_W-1:0] m_tap4,
  output logic              m_left,
  output logic              m_eol,
  output logic              m_eos
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  vwf_state_e        state;
  logic [COL_W-1:0]  col;
  logic [2:0]        cur_slot;   // slot receiving the current row
  logic [2:0]        last_slot;  // slot of the final row of the image
  logic [2:0]        row_cnt;    // row index, saturating at 7
  logic              odd_row;
  logic              short_img;  // image of exactly four rows

  logic              emit_row;
  logic              s_fire;
  logic              eb_in_valid;
  logic              eb_in_ready;
  logic              at_eol;

  logic [NUM_LINES-1:0][DATA_W-1:0] rd_lines;
  logic [4:0][2:0]                  tap_slot;
  logic [4:0][DATA_W-1:0]           mux_tap;
  logic [DATA_W-1:0]                tap4;
  logic                             left_flag;
  logic [PAY_W-1:0]                 eb_in_data;
  logic [PAY_W-1:0]                 eb_out_data;

  assign at_eol   = (col == LAST_COL);
  assign emit_row = (state == ST_RECV) && !odd_row && (row_cnt >= 3'd4);
  assign s_ready  = (state == ST_RECV) && (!emit_row || eb_in_ready);
  assign s_fire   = s_valid && s_ready;

  assign eb_in_valid = (state != ST_RECV) || (emit_row && s_valid);

  // tap row selection, including top and bottom mirroring
  always_comb begin
    tap_slot = '0;
    unique case (state)
      ST_RECV: begin
        tap_slot[0] = (row_cnt == 3'd4) ? slot_back(cur_slot, 3'd2) : slot_back(cur_slot, 3'd6);
        tap_slot[1] = slot_back(cur_slot, 3'd4);
        tap_slot[2] = slot_back(cur_slot, 3'd3);
        tap_slot[3] = slot_back(cur_slot, 3'd2);
        tap_slot[4] = cur_slot;
      end
      ST_DRAIN_A: begin
        tap_slot[0] = short_img ? slot_back(last_slot, 3'd1) : slot_back(last_slot, 3'd5);
        tap_slot[1] = slot_back(last_slot, 3'd3);
        tap_slot[2] = slot_back(last_slot, 3'd2);
        tap_slot[3] = slot_back(last_slot, 3'd1);
        tap_slot[4] = slot_back(last_slot, 3'd1);
      end
      default: begin
        tap_slot[0] = slot_back(last_slot, 3'd3);
        tap_slot[1] = slot_back(last_slot, 3'd1);
        tap_slot[2] = last_slot;
        tap_slot[3] = slot_back(last_slot, 3'd1);
        tap_slot[4] = slot_back(last_slot, 3'd3);
      end
    endcase
  end

  vwf_line_bank #(
    .DATA_W (DATA_W),
    .COLS   (COLS),
    .LINES  (NUM_LINES)
  ) bank_i (
    .clk      (clk),
    .wr_en    (s_fire),
    .wr_slot  (cur_slot),
    .col      (col),
    .wr_data  (s_data),
    .rd_lines (rd_lines)
  );

  for (genvar t = 0; t < 5; t++) begin : g_tap
    vwf_tap_mux #(
      .DATA_W (DATA_W),
      .LINES  (NUM_LINES)
    ) mux_i (
      .rd_lines (rd_lines),
      .sel      (tap_slot[t]),
      .tap      (mux_tap[t])
    );
  end

  assign tap4      = (state == ST_RECV) ? s_data : mux_tap[4];
  assign left_flag = (state == ST_RECV) ? (row_cnt == 3'd4) : ((state == ST_DRAIN_A) && short_img);

  assign eb_in_data = {left_flag, at_eol, (state == ST_DRAIN_B) && at_eol,
                       tap4, mux_tap[3], mux_tap[2], mux_tap[1], mux_tap[0]};

  vwf_elastic_buf #(
    .W (PAY_W)
  ) out_buf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (eb_in_valid),
    .in_ready  (eb_in_ready),
    .in_data   (eb_in_data),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (eb_out_data)
  );

  assign {m_left, m_eol, m_eos, m_tap4, m_tap3, m_tap2, m_tap1, m_tap0} = eb_out_data;

  // sequencing of rows, columns and the bottom drain
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RECV;
      col       <= '0;
      cur_slot  <= '0;
      last_slot <= '0;
      row_cnt   <= '0;
      odd_row   <= 1'b0;
      short_img <= 1'b0;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (s_fire) begin
            if (at_eol) begin
              col <= '0;
              if (s_eos) begin
                state     <= ST_DRAIN_A;
                last_slot <= cur_slot;
                short_img <= (row_cnt == 3'd3);
              end else begin
                cur_slot <= (cur_slot == 3'd6) ? 3'd0 : cur_slot + 3'd1;
                odd_row  <= !odd_row;
                if (row_cnt != 3'd7) row_cnt <= row_cnt + 3'd1;
              end
            end else begin
              col <= col + COL_W'(1);
            end
          end
        end
        default: begin
          if (eb_in_ready) begin
            if (at_eol) begin
              col <= '0;
              if (state == ST_DRAIN_A) begin
                state <= ST_DRAIN_B;
              end else begin
                state    <= ST_RECV;
                cur_slot <= '0;
                row_cnt  <= '0;
                odd_row  <= 1'b0;
              end
            end else begin
              col <= col + COL_W'(1);
            end
          end
        end
      endcase
    end
  end

  // R1: column counter never leaves the row
  p_col_in_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
    col <= LAST_COL);

  // R6: accepting the image's final sample closes the input side
  p_eos_closes_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_fire && s_eos && at_eol) |=> !s_ready);

  // R9: image end only appears on a row end
  p_eos_on_eol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_eos) |-> m_eol);

  // R5: the first-pair flag never reaches the final tuple
  p_left_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_left) |-> !m_eos);

endmodule

// File: tb/vwf_vertical_feeder_tb_top.sv
module vwf_vertical_feeder_tb_top;

  localparam int unsigned DATA_W = 20;
  localparam int unsigned COLS   = 5;

  typedef struct packed {
    logic [DATA_W-1:0] t0, t1, t2, t3, t4;
    logic left, eol, eos;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [DATA_W-1:0] s_data = '0;
  logic s_eos = 1'b0;
  logic m_valid;
  logic m_ready = 1'b0;
  logic [DATA_W-1:0] m_tap0, m_tap1, m_tap2, m_tap3, m_tap4;
  logic m_left, m_eol, m_eos;

  int checks = 0;
  int fails  = 0;
  int rx_cnt = 0;
  int exp_total = 0;
  int ready_mode = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  vwf_vertical_feeder #(.DATA_W(DATA_W), .COLS(COLS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_eos(s_eos),
    .m_valid(m_valid), .m_ready(m_ready),
    .m_tap0(m_tap0), .m_tap1(m_tap1), .m_tap2(m_tap2), .m_tap3(m_tap3), .m_tap4(m_tap4),
    .m_left(m_left), .m_eol(m_eol), .m_eos(m_eos)
  );

  function automatic logic [DATA_W-1:0] pix(int img, int r, int c);
    return DATA_W'(img * 4096 + r * 64 + c);
  endfunction

  function automatic int mir(int j, int n);
    if (j < 0) return -j;
    if (j > n - 1) return 2 * (n - 1) - j;
    return j;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // downstream ready pattern
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (ready_mode)
        0: m_ready = 1'b1;
        1: m_ready = ($urandom % 3) != 0;
        default: m_ready = (cyc % 16) >= 10;
      endcase
    end
  end

  // monitor / scoreboard
  logic prev_stall = 1'b0;
  exp_t prev_item;
  always @(negedge clk) begin
    exp_t got;
    got = '{m_tap0, m_tap1, m_tap2, m_tap3, m_tap4, m_left, m_eol, m_eos};
    if (rst_n) begin
      if (prev_stall) // R7 hold under back-pressure
        check(m_valid && (got == prev_item), "R7", "held tuple", {m_valid, got[15:0]}, {1'b1, prev_item[15:0]});
      prev_stall = m_valid && !m_ready;
      prev_item  = got;
      if (m_valid && m_ready) begin
        rx_cnt++;
        if (sb.size() == 0) begin
          check(1'b0, "R8", "unexpected tuple", got.t2, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          // R2 R3 R4 R10 tap contents, including mirrored rows
          check(got.t0 == e.t0 && got.t1 == e.t1 && got.t2 == e.t2, "R2", "taps 0-2",
                {got.t0, got.t1, got.t2}, {e.t0, e.t1, e.t2});
          check(got.t3 == e.t3 && got.t4 == e.t4, "R4", "taps 3-4 (R3 top)",
                {got.t3, got.t4}, {e.t3, e.t4});
          check(got.left == e.left, "R5", "left flag", got.left, e.left);
          check(got.eol == e.eol && got.eos == e.eos, "R9", "eol/eos", {got.eol, got.eos}, {e.eol, e.eos});
        end
      end
    end
  end

  task automatic push_expected(int img, int n);
    for (int p = 0; p < n / 2; p++) begin
      for (int c = 0; c < COLS; c++) begin
        exp_t e;
        e.t0 = pix(img, mir(2 * p - 2, n), c);
        e.t1 = pix(img, mir(2 * p, n), c);
        e.t2 = pix(img, mir(2 * p + 1, n), c);
        e.t3 = pix(img, mir(2 * p + 2, n), c);
        e.t4 = pix(img, mir(2 * p + 4, n), c);
        e.left = (p == 0);
        e.eol  = (c == COLS - 1);
        e.eos  = (p == n / 2 - 1) && (c == COLS - 1);
        sb.push_back(e);
        exp_total++;
      end
    end
  endtask

  task automatic send_image(int img, int n, bit gaps, bit chk_drain);
    push_expected(img, n);
    for (int r = 0; r < n; r++) begin
      for (int c = 0; c < COLS; c++) begin
        bit acc;
        if (gaps && ((r + c) % 3 == 0)) begin
          s_valid = 1'b0;
          @(posedge clk); #1;
        end
        s_valid = 1'b1;
        s_data  = pix(img, r, c);
        s_eos   = (r == n - 1) && (c == COLS - 1);
        do begin
          @(negedge clk); acc = s_ready;
          @(posedge clk); #1;
        end while (!acc);
      end
    end
    s_valid = 1'b0;
    s_eos   = 1'b0;
    if (chk_drain) begin
      int low = 0;
      forever begin
        @(negedge clk);
        if (s_ready) break;
        low++;
      end
      check(low == 2 * COLS, "R6", "input closed cycles", low, 2 * COLS);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!m_valid, "R1", "reset m_valid", m_valid, 0);
    check(s_ready, "R1", "reset s_ready", s_ready, 1);
    @(posedge clk); #1;

    ready_mode = 0;
    send_image(1, 6, 1'b0, 1'b1);   // R6 drain timing, R3/R4 both edges
    ready_mode = 1;
    send_image(2, 4, 1'b1, 1'b0);   // R10 back-to-back, four-row image
    ready_mode = 2;
    send_image(3, 10, 1'b0, 1'b0);  // R1 long image, long stalls
    ready_mode = 1;
    send_image(4, 8, 1'b1, 1'b0);   // R8 gaps plus random back-pressure

    for (int i = 0; i < 400 && sb.size() != 0; i++) @(negedge clk);
    check(sb.size() == 0, "R8", "tuples outstanding", sb.size(), 0);
    check(rx_cnt == exp_total, "R1", "tuple count", rx_cnt, exp_total);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #80000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule